// File: doc/BRIEF.md
# Interrupt vector ring writer

The block takes interrupt events from client sources, one at a time, and turns each into a 32-byte record of eight 32-bit words. The record goes into a circular buffer in system memory through a simple word write port. A byte-granular write pointer then moves past the new record. Software drains the buffer and reports its progress by writing a read pointer register. The block raises an interrupt line while unread records remain.

If the producer catches up with the consumer, a sticky overflow flag is set. The flag is visible as the top bit of the readable write pointer, and the block keeps writing over the oldest data rather than stalling its sources. Optionally, after every record, the block also stores the write pointer word, overflow bit included, at a programmed memory address. Software can then poll that memory word instead of reading the register.

Top module: `ivr_writer`

## Requirements
- R1: `evt_ready_o` is high only when no record is being written and control bits 0 (ring enable) and 1 (interrupt enable) are both set. An accepted event is followed by exactly 8 record write cycles, plus 1 writeback cycle when enabled, and no other memory writes.
- R2: The 8 words go out on the 8 consecutive cycles that follow the accepting clock edge. Word k is written at byte address base + wptr + 4k. The base is {base_hi[7:0] (offset 2), base_lo[31:0] (offset 1), 8'h00}.
- R3: Word 0 = {vm_valid, 3'b0, vm_id[3:0], ring[7:0], source[7:0], client[7:0]}, with the client in bits [7:0].
- R4: Word 1 is timestamp[31:0]. Word 2 is {ts_flag, 15'b0, timestamp[47:32]}. Word 3 is {proc_valid, 15'b0, proc_id[15:0]}.
- R5: Words 4 to 7 are payload[31:0], payload[63:32], payload[95:64] and payload[127:96], in that order.
- R6: After the last word, the write pointer advances by 32 modulo the ring length in bytes, 4 << size. The size is control bits [12:8], the log2 of the ring length in words, with a minimum of 3. The write pointer reads at offset 4 in bits [PTR_W-1:0].
- R7: With control bit 3 set, the cycle after word 7 writes {ovf, 0, wptr} (updated wptr, ovf in bit 31) to address {wb_hi[7:0] (offset 6), wb_lo[31:2] (offset 5), 2'b00}.
- R8: With control bit 2 set, accepting an event when (wptr + 32) masked equals the read pointer sets a sticky overflow flag, seen in bit 31 of the offset 4 read. A control write with bit 4 set clears the flag, and bit 4 reads 0. With bit 2 clear, the flag is never set.
- R9: `irq_o` rises on the cycle after the write pointer first differs from the read pointer while the ring is enabled. It falls on the cycle after a read pointer write makes the two equal.
- R10: Clearing either enable bit aborts any record in progress and forces the write pointer, the read pointer and the overflow flag to 0. It also holds `evt_ready_o` and `irq_o` low.
- R11: A write to the read pointer register (offset 3) stores the written value ANDed with the ring mask, 4 << size minus 1. The value reads back from the same offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Event offered |
| evt_ready_o | output | 1 | Event accepted on this edge when valid |
| evt_client_i | input | 8 | Client id |
| evt_src_i | input | 8 | Source id |
| evt_ring_i | input | 8 | Ring id |
| evt_vmid_i | input | 4 | VM id |
| evt_vmid_vld_i | input | 1 | VM id valid |
| evt_ts_i | input | 48 | Timestamp |
| evt_ts_src_i | input | 1 | Timestamp source flag |
| evt_proc_id_i | input | 16 | Process id |
| evt_proc_vld_i | input | 1 | Process id valid |
| evt_data_i | input | 128 | Four payload words |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from offset |
| mem_we_o | output | 1 | Memory word write |
| mem_addr_o | output | 48 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| irq_o | output | 1 | Unread records pending |

## Verification
Random events with random field values sweep every bit of the record layout. This tells a swapped or shifted field apart from a correct pack, and it also checks the word order in memory. Directed sequences drive the pointer through the wrap point of a four-record ring. They also approach a fixed read pointer with overflow detection on and then off, which separates "full" from "overflow" from "detection disabled". Random read pointer writes in a larger ring, interleaved with overflow clears, hit the overflow and interrupt conditions at arbitrary offsets. A disable-and-re-enable step confirms that both pointers and the flag really return to zero.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int WORD_W     = 32;
  localparam int VEC_WORDS  = 8;
  localparam int BEAT_W     = $clog2(VEC_WORDS);
  localparam int VEC_BYTES  = VEC_WORDS * 4;
  localparam int DATA_WORDS = 4;
  localparam int HI_W       = 8;
  localparam int BASE_SHIFT = 8;
  localparam int ADDR_W     = HI_W + WORD_W + BASE_SHIFT;
  localparam int SIZE_W     = 5;

  localparam int CB_RING_EN  = 0;
  localparam int CB_INTR_EN  = 1;
  localparam int CB_OVF_DET  = 2;
  localparam int CB_WB_EN    = 3;
  localparam int CB_OVF_CLR  = 4;
  localparam int CB_SIZE_LSB = 8;

  typedef enum logic [2:0] {
    RA_CTRL    = 3'd0,
    RA_BASE_LO = 3'd1,
    RA_BASE_HI = 3'd2,
    RA_RPTR    = 3'd3,
    RA_WPTR    = 3'd4,
    RA_WB_LO   = 3'd5,
    RA_WB_HI   = 3'd6,
    RA_RSVD    = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {ST_IDLE, ST_VEC, ST_WB} wr_state_e;

  typedef struct packed {
    logic [7:0]   client;
    logic [7:0]   src;
    logic [7:0]   ring;
    logic [3:0]   vmid;
    logic         vmid_vld;
    logic [47:0]  ts;
    logic         ts_src;
    logic [15:0]  proc_id;
    logic         proc_vld;
    logic [127:0] data;
  } ivr_event_t;

  typedef logic [VEC_WORDS-1:0][WORD_W-1:0] ivr_vec_t;
endpackage

// File: rtl/ivr_pack.sv
module ivr_pack
  import ivr_pkg::*;
(
  input  ivr_event_t evt_i,
  output ivr_vec_t   vec_o
);
  assign vec_o[0] = {evt_i.vmid_vld, 3'b0, evt_i.vmid, evt_i.ring, evt_i.src, evt_i.client};
  assign vec_o[1] = evt_i.ts[31:0];
  assign vec_o[2] = {evt_i.ts_src, 15'b0, evt_i.ts[47:32]};
  assign vec_o[3] = {evt_i.proc_vld, 15'b0, evt_i.proc_id};

  for (genvar g = 0; g < DATA_WORDS; g++) begin : g_data
    assign vec_o[VEC_WORDS-DATA_WORDS+g] = evt_i.data[g*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/ivr_regs.sv
module ivr_regs
  import ivr_pkg::*;
#(
  parameter int PTR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [PTR_W-1:0]  wptr_i,
  input  logic              ovf_i,
  output logic              active_o,
  output logic              ovf_det_o,
  output logic              wb_en_o,
  output logic              ovf_clr_o,
  output logic [PTR_W-1:0]  mask_o,
  output logic [PTR_W-1:0]  rptr_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] wb_addr_o
);
  localparam int PAD_W = WORD_W - 1 - PTR_W;

  reg_addr_e         ra;
  logic              ring_en_q, intr_en_q, det_q, wb_q;
  logic [SIZE_W-1:0] size_q;
  logic [31:0]       base_lo_q;
  logic [HI_W-1:0]   base_hi_q, wb_hi_q;
  logic [31:2]       wb_lo_q;
  logic [PTR_W-1:0]  rptr_q;
  logic [PTR_W:0]    span;

  assign ra        = reg_addr_e'(addr_i);
  assign active_o  = ring_en_q & intr_en_q;
  assign ovf_det_o = det_q;
  assign wb_en_o   = wb_q;
  assign ovf_clr_o = we_i && (ra == RA_CTRL) && wdata_i[CB_OVF_CLR];
  assign span      = (PTR_W+1)'(4) << size_q;
  assign mask_o    = PTR_W'(span - 1'b1);
  assign rptr_o    = rptr_q;
  assign base_o    = {base_hi_q, base_lo_q, {BASE_SHIFT{1'b0}}};
  assign wb_addr_o = ADDR_W'({wb_hi_q, wb_lo_q, 2'b00});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_en_q <= 1'b0;
      intr_en_q <= 1'b0;
      det_q     <= 1'b0;
      wb_q      <= 1'b0;
      size_q    <= SIZE_W'(3);
      base_lo_q <= '0;
      base_hi_q <= '0;
      wb_lo_q   <= '0;
      wb_hi_q   <= '0;
    end else if (we_i) begin
      case (ra)
        RA_CTRL: begin
          ring_en_q <= wdata_i[CB_RING_EN];
          intr_en_q <= wdata_i[CB_INTR_EN];
          det_q     <= wdata_i[CB_OVF_DET];
          wb_q      <= wdata_i[CB_WB_EN];
          size_q    <= wdata_i[CB_SIZE_LSB +: SIZE_W];
        end
        RA_BASE_LO: base_lo_q <= wdata_i;
        RA_BASE_HI: base_hi_q <= wdata_i[HI_W-1:0];
        RA_WB_LO:   wb_lo_q   <= wdata_i[31:2];
        RA_WB_HI:   wb_hi_q   <= wdata_i[HI_W-1:0];
        default: ;
      endcase
    end
  end

  // read pointer is held at zero while the ring is off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      rptr_q <= '0;
    else if (!active_o)               rptr_q <= '0;
    else if (we_i && ra == RA_RPTR)   rptr_q <= wdata_i[PTR_W-1:0] & mask_o;
  end

  always_comb begin
    rdata_o = '0;
    case (ra)
      RA_CTRL: begin
        rdata_o[CB_RING_EN]              = ring_en_q;
        rdata_o[CB_INTR_EN]              = intr_en_q;
        rdata_o[CB_OVF_DET]              = det_q;
        rdata_o[CB_WB_EN]                = wb_q;
        rdata_o[CB_SIZE_LSB +: SIZE_W]   = size_q;
      end
      RA_BASE_LO: rdata_o = base_lo_q;
      RA_BASE_HI: rdata_o = 32'(base_hi_q);
      RA_RPTR:    rdata_o = 32'(rptr_q);
      RA_WPTR:    rdata_o = {ovf_i, {PAD_W{1'b0}}, wptr_i};
      RA_WB_LO:   rdata_o = {wb_lo_q, 2'b00};
      RA_WB_HI:   rdata_o = 32'(wb_hi_q);
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ivr_seq.sv
module ivr_seq
  import ivr_pkg::*;
#(
  parameter int PTR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              ovf_det_i,
  input  logic              wb_en_i,
  input  logic              ovf_clr_i,
  input  logic [PTR_W-1:0]  mask_i,
  input  logic [PTR_W-1:0]  rptr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] wb_addr_i,
  input  logic              evt_valid_i,
  input  ivr_vec_t          vec_i,
  output logic              evt_ready_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic [PTR_W-1:0]  wptr_o,
  output logic              ovf_o,
  output logic              irq_o
);
  localparam int PAD_W = WORD_W - 1 - PTR_W;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(VEC_WORDS - 1);

  wr_state_e        state_q;
  logic [BEAT_W-1:0] beat_q;
  ivr_vec_t         vec_q;
  logic [PTR_W-1:0] wptr_q, wptr_nxt;
  logic             ovf_q, irq_q, accept, ovf_set;

  assign wptr_nxt    = (wptr_q + PTR_W'(VEC_BYTES)) & mask_i;
  assign evt_ready_o = active_i && (state_q == ST_IDLE);
  assign accept      = evt_valid_i && evt_ready_o;
  assign ovf_set     = accept && ovf_det_i && (wptr_nxt == rptr_i);
  assign wptr_o      = wptr_q;
  assign ovf_o       = ovf_q;
  assign irq_o       = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      vec_q   <= '0;
      wptr_q  <= '0;
      ovf_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else if (!active_i) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      wptr_q  <= '0;
      ovf_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      ovf_q <= ovf_set | (ovf_q & ~ovf_clr_i);
      irq_q <= (wptr_q != rptr_i);
      case (state_q)
        ST_IDLE: if (accept) begin
          vec_q   <= vec_i;
          beat_q  <= '0;
          state_q <= ST_VEC;
        end
        ST_VEC: begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == LAST_BEAT) begin
            wptr_q  <= wptr_nxt;
            state_q <= wb_en_i ? ST_WB : ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_we_o    = active_i && (state_q != ST_IDLE);
    mem_addr_o  = base_i + ADDR_W'(wptr_q) + ADDR_W'({beat_q, 2'b00});
    mem_wdata_o = vec_q[beat_q];
    if (state_q == ST_WB) begin
      mem_addr_o  = wb_addr_i;
      mem_wdata_o = {ovf_q, {PAD_W{1'b0}}, wptr_q};
    end
  end
endmodule

// File: rtl/ivr_writer.sv
module ivr_writer
  import ivr_pkg::*;
#(
  parameter int PTR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_valid_i,
  output logic              evt_ready_o,
  input  logic [7:0]        evt_client_i,
  input  logic [7:0]        evt_src_i,
  input  logic [7:0]        evt_ring_i,
  input  logic [3:0]        evt_vmid_i,
  input  logic              evt_vmid_vld_i,
  input  logic [47:0]       evt_ts_i,
  input  logic              evt_ts_src_i,
  input  logic [15:0]       evt_proc_id_i,
  input  logic              evt_proc_vld_i,
  input  logic [127:0]      evt_data_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  output logic              irq_o
);
  ivr_event_t        evt;
  ivr_vec_t          vec;
  logic              ring_active, ovf_det, wb_en, ovf_clr, ovf;
  logic [PTR_W-1:0]  rng_mask, rptr, wptr;
  logic [ADDR_W-1:0] base, wb_addr;

  assign evt = '{client: evt_client_i, src: evt_src_i, ring: evt_ring_i,
                 vmid: evt_vmid_i, vmid_vld: evt_vmid_vld_i, ts: evt_ts_i,
                 ts_src: evt_ts_src_i, proc_id: evt_proc_id_i,
                 proc_vld: evt_proc_vld_i, data: evt_data_i};

  ivr_pack u_pack (.evt_i(evt), .vec_o(vec));

  ivr_regs #(.PTR_W(PTR_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .wptr_i(wptr), .ovf_i(ovf),
    .active_o(ring_active), .ovf_det_o(ovf_det), .wb_en_o(wb_en), .ovf_clr_o(ovf_clr),
    .mask_o(rng_mask), .rptr_o(rptr), .base_o(base), .wb_addr_o(wb_addr)
  );

  ivr_seq #(.PTR_W(PTR_W)) u_seq (
    .clk_i, .rst_ni,
    .active_i(ring_active), .ovf_det_i(ovf_det), .wb_en_i(wb_en), .ovf_clr_i(ovf_clr),
    .mask_i(rng_mask), .rptr_i(rptr), .base_i(base), .wb_addr_i(wb_addr),
    .evt_valid_i, .vec_i(vec), .evt_ready_o,
    .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .wptr_o(wptr), .ovf_o(ovf), .irq_o
  );
endmodule

// File: rtl/ivr_writer_chk.sv
module ivr_writer_chk #(
  parameter int PTR_W = 20
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             evt_valid_i,
  input logic             evt_ready_i,
  input logic             mem_we_i,
  input logic [1:0]       mem_addr_lsb_i,
  input logic             irq_i,
  input logic             active_i,
  input logic [PTR_W-1:0] wptr_i,
  input logic [PTR_W-1:0] mask_i,
  input logic             ovf_i,
  input logic             ovf_clr_i
);
  a_r1_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> !evt_ready_i);

  a_r2_accept_starts_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_ready_i) |=> mem_we_i);

  a_r2_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> (mem_addr_lsb_i == 2'b00));

  a_r6_wptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wptr_i) |-> (wptr_i == '0 ||
      wptr_i == (($past(wptr_i) + PTR_W'(32)) & $past(mask_i))));

  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && active_i && !ovf_clr_i) |=> ovf_i);

  a_r10_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> (!mem_we_i && !evt_ready_i));

  a_r10_off_ptr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (wptr_i == '0 && !ovf_i));

  a_r9_irq_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !irq_i);
endmodule

bind ivr_writer ivr_writer_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .evt_valid_i(evt_valid_i), .evt_ready_i(evt_ready_o),
  .mem_we_i(mem_we_o), .mem_addr_lsb_i(mem_addr_o[1:0]),
  .irq_i(irq_o), .active_i(ring_active),
  .wptr_i(wptr), .mask_i(rng_mask), .ovf_i(ovf), .ovf_clr_i(ovf_clr)
);

// File: tb/tb_ivr_writer.sv
module tb_ivr_writer;
  localparam int PTR_W = 20;
  localparam int AW = 48;

  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_valid = 0, evt_ready;
  logic [7:0] e_client = 0, e_src = 0, e_ring = 0;
  logic [3:0] e_vmid = 0;
  logic e_vmid_vld = 0, e_ts_src = 0, e_proc_vld = 0;
  logic [47:0] e_ts = 0;
  logic [15:0] e_proc = 0;
  logic [127:0] e_data = 0;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_we, irq;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;

  int checks = 0, fails = 0;
  logic [AW-1:0] q_addr[$];
  logic [31:0] q_data[$];

  logic [31:0] ctrl_v;
  logic [PTR_W-1:0] exp_wptr, exp_rptr, exp_mask;
  logic exp_ovf;
  logic [AW-1:0] exp_base, exp_wb;

  always #4 clk = ~clk;

  ivr_writer #(.PTR_W(PTR_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .evt_valid_i(evt_valid), .evt_ready_o(evt_ready),
    .evt_client_i(e_client), .evt_src_i(e_src), .evt_ring_i(e_ring),
    .evt_vmid_i(e_vmid), .evt_vmid_vld_i(e_vmid_vld), .evt_ts_i(e_ts),
    .evt_ts_src_i(e_ts_src), .evt_proc_id_i(e_proc), .evt_proc_vld_i(e_proc_vld),
    .evt_data_i(e_data),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .irq_o(irq)
  );

  always @(negedge clk) if (mem_we) begin
    q_addr.push_back(mem_addr);
    q_data.push_back(mem_wdata);
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [PTR_W-1:0] mask_of(input logic [31:0] c);
    return PTR_W'((64'd4 << c[12:8]) - 1);
  endfunction

  function automatic logic [31:0] exp_word(input int k);
    case (k)
      0: return {e_vmid_vld, 3'b0, e_vmid, e_ring, e_src, e_client};
      1: return e_ts[31:0];
      2: return {e_ts_src, 15'b0, e_ts[47:32]};
      3: return {e_proc_vld, 15'b0, e_proc};
      default: return e_data[(k-4)*32 +: 32];
    endcase
  endfunction

  function automatic logic [31:0] wptr_word();
    return {exp_ovf, 11'b0, exp_wptr};
  endfunction

  task automatic rand_evt();
    e_client = 8'($urandom); e_src = 8'($urandom); e_ring = 8'($urandom);
    e_vmid = 4'($urandom); e_vmid_vld = 1'($urandom);
    e_ts = {16'($urandom), $urandom}; e_ts_src = 1'($urandom);
    e_proc = 16'($urandom); e_proc_vld = 1'($urandom);
    e_data = {$urandom, $urandom, $urandom, $urandom};
  endtask

  task automatic send_chk();
    logic [PTR_W-1:0] nxt;
    int n;
    rand_evt();
    q_addr.delete(); q_data.delete();
    nxt = (exp_wptr + PTR_W'(32)) & exp_mask;
    if (ctrl_v[2] && nxt == exp_rptr) exp_ovf = 1'b1;
    @(negedge clk);
    evt_valid = 1;
    while (!evt_ready) @(negedge clk);
    @(negedge clk);
    evt_valid = 0;
    repeat (12) @(negedge clk);
    n = 8 + int'(ctrl_v[3]);
    chk("R1 write count", 64'(q_addr.size()), 64'(n));
    if (q_addr.size() == n) begin
      for (int k = 0; k < 8; k++) begin
        chk("R2 word address", 64'(q_addr[k]), 64'(exp_base + AW'(exp_wptr) + AW'(4*k)));
        if (k == 0)     chk("R3 header word", 64'(q_data[k]), 64'(exp_word(k)));
        else if (k < 4) chk("R4 time/proc word", 64'(q_data[k]), 64'(exp_word(k)));
        else            chk("R5 payload word", 64'(q_data[k]), 64'(exp_word(k)));
      end
    end
    exp_wptr = nxt;
    if (ctrl_v[3] && q_addr.size() == n) begin
      chk("R7 writeback address", 64'(q_addr[8]), 64'(exp_wb));
      chk("R7 writeback data", 64'(q_data[8]), 64'(wptr_word()));
    end
    chk("R9 irq after record", 64'(irq), 64'(exp_wptr != exp_rptr));
  endtask

  task automatic wptr_chk(input string tag);
    logic [31:0] d;
    rd(3'd4, d);
    chk(tag, 64'(d), 64'(wptr_word()));
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    exp_wptr = 0; exp_rptr = 0; exp_ovf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset ready", 64'(evt_ready), 64'd0);
    chk("R9 reset irq", 64'(irq), 64'd0);
    wptr_chk("R6 reset wptr");

    // base 0xA5_0012_3400_00
    wr(3'd1, 32'h0012_3400);
    wr(3'd2, 32'h0000_00A5);
    exp_base = {8'hA5, 32'h0012_3400, 8'h00};
    wr(3'd5, 32'h0000_8007);
    wr(3'd6, 32'h0000_0003);
    exp_wb = AW'({8'h03, 32'h0000_8004});

    ctrl_v = 32'h0000_0501;  // ring enable only, size 5 (128 bytes)
    wr(3'd0, ctrl_v);
    @(negedge clk);
    chk("R1 ready needs both enables", 64'(evt_ready), 64'd0);
    ctrl_v = 32'h0000_0507;
    wr(3'd0, ctrl_v);
    exp_mask = mask_of(ctrl_v);
    chk("R1 ready when enabled", 64'(evt_ready), 64'd1);

    for (int i = 0; i < 3; i++) begin
      send_chk();
      wptr_chk("R6 wptr advance");
    end

    // read pointer catch-up drops irq one cycle later
    @(negedge clk);
    reg_we = 1; reg_addr = 3'd3; reg_wdata = 32'd96;
    @(negedge clk);
    reg_we = 0;
    exp_rptr = 96;
    chk("R9 irq still high right after rptr write", 64'(irq), 64'd1);
    @(negedge clk);
    chk("R9 irq low one cycle later", 64'(irq), 64'd0);

    ctrl_v = 32'h0000_050F;  // add writeback
    wr(3'd0, ctrl_v);
    send_chk();  // wraps 96 -> 0
    wptr_chk("R6 wrap to zero");
    for (int i = 0; i < 3; i++) send_chk();  // third one overflows
    wptr_chk("R8 overflow flag set");

    wr(3'd0, ctrl_v | 32'h10);
    exp_ovf = 0;
    wptr_chk("R8 overflow cleared");
    rd(3'd0, d);
    chk("R8 clear bit reads zero", 64'(d[4]), 64'd0);

    ctrl_v = 32'h0000_050B;  // detection off
    wr(3'd0, ctrl_v);
    wr(3'd3, 32'd32);
    exp_rptr = 32;
    send_chk();
    send_chk();
    wptr_chk("R8 no flag with detection off");

    wr(3'd0, 32'h0);
    exp_wptr = 0; exp_rptr = 0; exp_ovf = 0;
    @(negedge clk);
    wptr_chk("R10 wptr zero when off");
    rd(3'd3, d);
    chk("R10 rptr zero when off", 64'(d), 64'd0);
    chk("R10 ready low when off", 64'(evt_ready), 64'd0);
    chk("R10 irq low when off", 64'(irq), 64'd0);

    ctrl_v = 32'h0000_060F;  // size 6, 256 bytes
    wr(3'd0, ctrl_v);
    exp_mask = mask_of(ctrl_v);
    wr(3'd3, 32'hABCD_E0E0);
    exp_rptr = 32'hABCD_E0E0 & 32'(exp_mask);
    rd(3'd3, d);
    chk("R11 rptr masked", 64'(d), 64'(exp_rptr));

    for (int i = 0; i < 24; i++) begin
      if ($urandom % 3 == 0) begin
        d = $urandom & 32'hFFFF_FFE0;
        wr(3'd3, d);
        exp_rptr = d[PTR_W-1:0] & exp_mask;
        @(negedge clk);
        chk("R9 irq after rptr write", 64'(irq), 64'(exp_wptr != exp_rptr));
      end
      if ($urandom % 5 == 0) begin
        wr(3'd0, ctrl_v | 32'h10);
        exp_ovf = 0;
      end
      send_chk();
      wptr_chk("R6 R8 random wptr");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule